// File: doc/BRIEF.md
# MESI Coherent L1 Line Controller with Locked Fetch-Add

This block is the coherence engine of one core's small direct-mapped data cache. Every line carries one of four MESI states (Invalid, Shared, Exclusive, Modified) beside its tag and one data word. The core issues loads, stores and an atomic fetch-and-add. The block keeps each line coherent with a single peer controller over a shared snooping bus. The bus carries three transaction kinds: a plain read, a read-for-ownership that kills every other copy, and a write-back of dirty data.

A bus owner outside the block grants the bus to one transaction at a time. It forwards each read or read-for-ownership as a snoop to the peer. If the peer answers dirty, its data goes into the next level. The owner then completes the transaction toward the requester with the line data and the peer's shared flag. The bus owner must never raise a grant in a cycle when it is presenting a snoop to the same controller.

An atomic fetch-and-add pins its line in Modified for a fixed number of modify cycles. No snoop is answered while the line is pinned, so a peer that reads the line sees only the value after the add.

Top module: `mesi_line_ctrl`

## Requirements
- R1: A store or fetch-and-add changes line data only while the line is Exclusive or Modified, and the line is Modified when the core is acknowledged.
- R2: A store or fetch-and-add to a line that is Shared or absent first issues a read-for-ownership (bus code 2). The core is acknowledged only after that transaction completes.
- R3: A read-for-ownership snoop that hits a local copy invalidates it, so the next local load of that address misses and fetches the current value over the bus.
- R4: A read snoop (bus code 1) that hits a Modified line replies with both the dirty and shared flags set and with the line data. The line drops to Shared, and the requesting core receives the written value.
- R5: A load that hits a valid local copy returns the local word one cycle after the request, with no bus transaction.
- R6: A fetch-and-add (core op code 2) returns the old word and writes old plus the operand after MOD_CYC cycles. Snoops on this controller stay unanswered until that write has committed.
- R7: A read miss fills the line Exclusive when the shared flag of the completion is low, and Shared when it is high.
- R8: A store (core op code 1) that hits an Exclusive line completes with no bus transaction.
- R9: The controller holds its bus request until granted and drops it on the cycle after the grant. Its commands use code 1 for read, 2 for read-for-ownership and 3 for write-back. Core op code 0 is a load, and code 3 also acts as a load.
- R10: A miss whose target line holds a different Modified address first writes that word back (bus code 3), then fetches. A miss whose target line holds a clean address fetches directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | Core request, held until core_ack |
| core_op | input | 2 | 0 load, 1 store, 2 fetch-and-add, 3 load |
| core_addr | input | ADDR_W | Word address |
| core_wdata | input | DATA_W | Store data or add operand |
| core_ack | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Load data or old value of fetch-and-add |
| bus_req | output | 1 | Request for the snooping bus |
| bus_cmd | output | 2 | 1 read, 2 read-for-ownership, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | One-cycle grant |
| bus_done | input | 1 | One-cycle completion of the granted transaction |
| bus_rdata | input | DATA_W | Fill data |
| bus_shared | input | 1 | Peer held a copy |
| snp_valid | input | 1 | Snoop from the peer's transaction, held until snp_ack |
| snp_cmd | input | 2 | Snooped command, 1 or 2 |
| snp_addr | input | ADDR_W | Snooped address |
| snp_ack | output | 1 | One-cycle snoop reply |
| snp_shared | output | 1 | Snoop hit a valid local copy |
| snp_dirty | output | 1 | Snoop hit a Modified line, snp_data is valid |
| snp_data | output | DATA_W | Dirty line data |

## Verification
Most wrong line states show up at the ports within one or two transactions. A line left valid after an ownership snoop makes a later load hit, return stale data in one cycle and issue no bus command. A line wrongly marked Shared turns a silent store into a read-for-ownership. A lost Modified state makes a peer read come back with the old memory value and no dirty flag. A snoop answered inside the lock window shows up as the peer reading the pre-add value.

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 4,
  parameter int MOD_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic [1:0]        core_op,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_ack,
  output logic [DATA_W-1:0] core_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_ack,
  output logic              snp_shared,
  output logic              snp_dirty,
  output logic [DATA_W-1:0] snp_data
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int CW    = $clog2(MOD_CYC + 1);
  localparam logic [CW-1:0] CLAST = CW'(MOD_CYC - 1);

  localparam logic [1:0] LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2, LS_M = 2'd3;
  localparam logic [1:0] BC_RD = 2'd1, BC_OWN = 2'd2, BC_WB = 2'd3;
  localparam logic [1:0] OP_ST = 2'd1, OP_AT = 2'd2;

  typedef enum logic [1:0] {C_IDLE, C_BUS, C_WAIT, C_RMW} cst_t;

  logic [1:0]        st [SETS];
  logic [TAG_W-1:0]  tg [SETS];
  logic [DATA_W-1:0] dt [SETS];
  cst_t              cs;
  logic [CW-1:0]     cnt;
  logic [1:0]        cmd_q;

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag;
  logic [1:0]       cur_st;
  logic             c_match, c_own, s_match, victim_dirty, is_ld, lock, snp_take;

  assign c_idx   = core_addr[IDX_W-1:0];
  assign c_tag   = core_addr[ADDR_W-1:IDX_W];
  assign s_idx   = snp_addr[IDX_W-1:0];
  assign s_tag   = snp_addr[ADDR_W-1:IDX_W];
  assign cur_st  = st[c_idx];
  assign c_match = (cur_st != LS_I) && (tg[c_idx] == c_tag);
  assign c_own   = c_match && (cur_st == LS_M || cur_st == LS_E);
  assign s_match = (st[s_idx] != LS_I) && (tg[s_idx] == s_tag);
  assign is_ld   = (core_op != OP_ST) && (core_op != OP_AT);
  assign victim_dirty = (cur_st == LS_M) && (tg[c_idx] != c_tag);

  assign lock     = (cs == C_RMW);
  assign snp_take = snp_valid && !snp_ack && !lock;

  assign bus_req   = (cs == C_BUS);
  assign bus_cmd   = victim_dirty ? BC_WB : (is_ld ? BC_RD : BC_OWN);
  assign bus_addr  = victim_dirty ? {tg[c_idx], c_idx} : core_addr;
  assign bus_wdata = dt[c_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        st[i] <= LS_I;
        tg[i] <= '0;
        dt[i] <= '0;
      end
      cs         <= C_IDLE;
      cnt        <= '0;
      cmd_q      <= BC_RD;
      core_ack   <= 1'b0;
      core_rdata <= '0;
      snp_ack    <= 1'b0;
      snp_shared <= 1'b0;
      snp_dirty  <= 1'b0;
      snp_data   <= '0;
    end else begin
      core_ack <= 1'b0;
      snp_ack  <= 1'b0;
      if (snp_take) begin
        snp_ack    <= 1'b1;
        snp_shared <= s_match;
        snp_dirty  <= s_match && (st[s_idx] == LS_M);
        snp_data   <= dt[s_idx];
        if (s_match) st[s_idx] <= (snp_cmd == BC_OWN) ? LS_I : LS_S;
      end else begin
        case (cs)
          C_IDLE: if (core_req && !core_ack) begin
            if (is_ld && c_match) begin
              core_rdata <= dt[c_idx];
              core_ack   <= 1'b1;
            end else if (core_op == OP_ST && c_own) begin
              dt[c_idx]  <= core_wdata;
              st[c_idx]  <= LS_M;
              core_ack   <= 1'b1;
            end else if (core_op == OP_AT && c_own) begin
              st[c_idx]  <= LS_M;
              core_rdata <= dt[c_idx];
              cnt        <= '0;
              cs         <= C_RMW;
            end else begin
              cs <= C_BUS;
            end
          end
          C_BUS: if (bus_gnt) begin
            cmd_q <= bus_cmd;
            cs    <= C_WAIT;
          end
          C_WAIT: if (bus_done) begin
            if (cmd_q == BC_WB) begin
              st[c_idx] <= LS_I;
            end else begin
              tg[c_idx] <= c_tag;
              dt[c_idx] <= bus_rdata;
              st[c_idx] <= (cmd_q == BC_OWN) ? LS_M : (bus_shared ? LS_S : LS_E);
            end
            cs <= C_IDLE;
          end
          C_RMW: begin
            if (cnt == CLAST) begin
              dt[c_idx] <= dt[c_idx] + core_wdata;
              core_ack  <= 1'b1;
              cs        <= C_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: cs <= C_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       core_ack,
  input logic [1:0] core_op,
  input logic [1:0] cur_st,
  input logic       lock,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       snp_ack,
  input logic       snp_shared,
  input logic       snp_dirty
);
  assert_write_owned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ack && (core_op == 2'd1 || core_op == 2'd2)) |-> (cur_st == 2'd3));

  assert_dirty_is_shared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_ack && snp_dirty) |-> snp_shared);

  assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    core_ack |=> !core_ack);

  assert_snoop_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> !snp_ack);

  assert_locked_modified_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (cur_st == 2'd3));

  assert_req_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |=> !bus_req);

  assert_snoop_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_ack |=> !snp_ack);
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_ack(core_ack), .core_op(core_op),
  .cur_st(cur_st), .lock(lock), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .snp_ack(snp_ack), .snp_shared(snp_shared), .snp_dirty(snp_dirty)
);

// File: tb/mesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb;
  localparam int AW = 6, DW = 16, IW = 2, MC = 4;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, AT = 2'd2;
  localparam logic [1:0] CRD = 2'd1, COWN = 2'd2, CWB = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req[2], ack[2], breq[2], gnt[2], bdone[2], bsh[2];
  logic sv[2], sack[2], ssh[2], sdirty[2];
  logic [1:0] op[2], bcmd[2], sc[2];
  logic [AW-1:0] ad[2], baddr[2], sa[2];
  logic [DW-1:0] wd[2], rd[2], bwd[2], brd[2], sdat[2];

  logic [DW-1:0] mem [64];
  int txn_cnt = 0;
  logic [1:0] txn_cmd [256];
  int txn_own [256];
  logic last_sh = 1'b0, last_dirty = 1'b0;
  int n_cmp = 0, n_bad = 0;

  mesi_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .MOD_CYC(MC)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_req(req[0]), .core_op(op[0]), .core_addr(ad[0]),
    .core_wdata(wd[0]), .core_ack(ack[0]), .core_rdata(rd[0]), .bus_req(breq[0]),
    .bus_cmd(bcmd[0]), .bus_addr(baddr[0]), .bus_wdata(bwd[0]), .bus_gnt(gnt[0]),
    .bus_done(bdone[0]), .bus_rdata(brd[0]), .bus_shared(bsh[0]), .snp_valid(sv[0]),
    .snp_cmd(sc[0]), .snp_addr(sa[0]), .snp_ack(sack[0]), .snp_shared(ssh[0]),
    .snp_dirty(sdirty[0]), .snp_data(sdat[0]));

  mesi_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .MOD_CYC(MC)) u_peer (
    .clk(clk), .rst_n(rst_n), .core_req(req[1]), .core_op(op[1]), .core_addr(ad[1]),
    .core_wdata(wd[1]), .core_ack(ack[1]), .core_rdata(rd[1]), .bus_req(breq[1]),
    .bus_cmd(bcmd[1]), .bus_addr(baddr[1]), .bus_wdata(bwd[1]), .bus_gnt(gnt[1]),
    .bus_done(bdone[1]), .bus_rdata(brd[1]), .bus_shared(bsh[1]), .snp_valid(sv[1]),
    .snp_cmd(sc[1]), .snp_addr(sa[1]), .snp_ack(sack[1]), .snp_shared(ssh[1]),
    .snp_dirty(sdirty[1]), .snp_data(sdat[1]));

  function automatic logic [DW-1:0] iv(int a);
    return DW'(a * 7 + 3);
  endfunction

  // bus owner: fixed priority, core 0 first; next level is mem
  initial begin : bus_engine
    int w, o;
    logic [1:0] c;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic sh;
    for (int i = 0; i < 64; i++) mem[i] = iv(i);
    for (int i = 0; i < 2; i++) begin
      gnt[i] = 0; bdone[i] = 0; bsh[i] = 0; brd[i] = '0;
      sv[i] = 0; sc[i] = 2'd0; sa[i] = '0;
    end
    forever begin
      @(negedge clk);
      if (rst_n && (breq[0] || breq[1])) begin
        w = breq[0] ? 0 : 1;
        o = 1 - w;
        c = bcmd[w]; a = baddr[w]; d = bwd[w];
        if (txn_cnt < 256) begin txn_cmd[txn_cnt] = c; txn_own[txn_cnt] = w; end
        txn_cnt++;
        gnt[w] = 1;
        @(negedge clk);
        gnt[w] = 0;
        if (c == CWB) begin
          mem[a] = d; sh = 0; last_dirty = 0;
        end else begin
          sv[o] = 1; sc[o] = c; sa[o] = a;
          do @(negedge clk); while (!sack[o]);
          sv[o] = 0;
          last_dirty = sdirty[o];
          if (sdirty[o]) mem[a] = sdat[o];
          sh = ssh[o];
        end
        last_sh = sh;
        bdone[w] = 1; brd[w] = mem[a]; bsh[w] = sh;
        @(negedge clk);
        bdone[w] = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input int c, input logic [1:0] o, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output logic [DW-1:0] r, output int cyc);
    @(negedge clk);
    op[c] = o; ad[c] = a; wd[c] = d; req[c] = 1; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!ack[c]);
    r = rd[c];
    req[c] = 0;
    @(negedge clk);
  endtask

  task automatic t_reset_and_exclusive;
    logic [DW-1:0] r; int cy, n;
    chk("reset core_ack", {31'd0, ack[0]}, 0);
    chk("reset bus_req R9", {31'd0, breq[0] | breq[1]}, 0);
    n = txn_cnt;
    do_op(0, LD, 8, 0, r, cy);
    chk("R7 cold load value", r, iv(8));
    chk("R9 cold load uses read code", txn_cmd[n], CRD);
    chk("R7 unshared fill flag", {31'd0, last_sh}, 0);
    do_op(0, LD, 8, 0, r, cy);
    chk("R5 hit latency", cy, 1);
    chk("R5 hit no bus", txn_cnt, n + 1);
    do_op(0, ST, 8, 16'h0100, r, cy);
    chk("R8 store on Exclusive is silent", txn_cnt, n + 1);
    chk("R8 store latency", cy, 1);
  endtask

  task automatic t_dirty_read;
    logic [DW-1:0] r; int cy, n;
    n = txn_cnt;
    do_op(1, LD, 8, 0, r, cy);
    chk("R4 peer reads written value", r, 16'h0100);
    chk("R4 snoop reply dirty", {31'd0, last_dirty}, 1);
    chk("R4 written back to memory", mem[8], 16'h0100);
    chk("R4 one read transaction", txn_cnt, n + 1);
    do_op(0, LD, 8, 0, r, cy);
    chk("R4 owner keeps Shared copy", cy, 1);
    chk("R4 owner copy value", r, 16'h0100);
  endtask

  task automatic t_upgrade;
    logic [DW-1:0] r; int cy, n;
    do_op(0, LD, 13, 0, r, cy);
    do_op(1, LD, 13, 0, r, cy);
    chk("R7 shared flag on second reader", {31'd0, last_sh}, 1);
    chk("R7 second reader value", r, iv(13));
    n = txn_cnt;
    do_op(1, ST, 13, 16'h0055, r, cy);
    chk("R2 store on Shared issues ownership read", txn_cnt, n + 1);
    chk("R2 ownership code", txn_cmd[n], COWN);
    chk("R2 store waits for bus", {31'd0, cy > 2}, 1);
    n = txn_cnt;
    do_op(0, LD, 13, 0, r, cy);
    chk("R3 invalidated copy misses", txn_cnt, n + 1);
    chk("R3 no stale value", r, 16'h0055);
    chk("R3 dirty reply from new owner", {31'd0, last_dirty}, 1);
  endtask

  task automatic t_atomic;
    logic [DW-1:0] r0, r1; int c0, c1, n;
    do_op(0, ST, 3, 16'd10, r0, c0);
    fork
      do_op(0, AT, 3, 16'd5, r0, c0);
      begin @(negedge clk); do_op(1, LD, 3, 0, r1, c1); end
    join
    chk("R6 fetch-add returns old", r0, 16'd10);
    chk("R6 fetch-add latency", c0, MC + 1);
    chk("R6 snoop held until commit", r1, 16'd15);
    do_op(0, LD, 3, 0, r0, c0);
    chk("R6 owner copy after add", r0, 16'd15);
    n = txn_cnt;
    do_op(1, AT, 20, 16'd1, r1, c1);
    chk("R2 fetch-add on absent line", txn_cmd[n], COWN);
    chk("R6 fetch-add old from memory", r1, iv(20));
    do_op(0, LD, 20, 0, r0, c0);
    chk("R6 committed add visible", r0, iv(20) + 16'd1);
  endtask

  task automatic t_evict;
    logic [DW-1:0] r; int cy, n;
    do_op(0, ST, 6, 16'h0077, r, cy);
    n = txn_cnt;
    do_op(0, LD, 10, 0, r, cy);
    chk("R10 dirty eviction count", txn_cnt, n + 2);
    chk("R10 write-back first", txn_cmd[n], CWB);
    chk("R10 then read", txn_cmd[n + 1], CRD);
    chk("R10 memory holds evicted word", mem[6], 16'h0077);
    chk("R10 new line value", r, iv(10));
    n = txn_cnt;
    do_op(0, LD, 14, 0, r, cy);
    chk("R10 clean eviction is silent", txn_cnt, n + 1);
    do_op(1, LD, 6, 0, r, cy);
    chk("R10 peer sees evicted data", r, 16'h0077);
  endtask

  task automatic t_arb;
    logic [DW-1:0] r0, r1; int c0, c1, n;
    n = txn_cnt;
    fork
      do_op(0, LD, 45, 0, r0, c0);
      do_op(1, 2'd3, 50, 0, r1, c1);
    join
    chk("R9 both served", txn_cnt, n + 2);
    chk("R9 core 0 first", txn_own[n], 0);
    chk("R9 core 1 second", txn_own[n + 1], 1);
    chk("R9 value core 0", r0, iv(45));
    chk("R9 op code 3 loads", r1, iv(50));
    chk("R9 op code 3 read code", txn_cmd[n + 1], CRD);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 2; i++) begin
      req[i] = 0; op[i] = 2'd0; ad[i] = '0; wd[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    t_reset_and_exclusive();
    t_dirty_read();
    t_upgrade();
    t_atomic();
    t_evict();
    t_arb();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule